// File: doc/BRIEF.md
# Melody Tone Sequencer

This block plays a tune on one square-wave output pin. Each note is a 16-bit word fetched from an on-chip note ROM through a read port with combinational data return. The word carries a pitch divider, a tone-length code and a marker for the final note. One global tempo setting stretches or shrinks every note. Playback starts on a rising edge of the run control and walks the ROM from a start address. It stops after the marked note and pulses an end interrupt for one cycle.

The block is clocked by the base tick. With a 32.768 kHz base, dividers 11 to 62 cover roughly 529 Hz to 2979 Hz. A second mode drives the pin with a fixed square wave at one eighth of the base clock, which is 4 kHz at that base. In this mode nothing is read from the ROM. Clearing the run control stops either mode at once, and no interrupt is raised.

Top module: `melody_seq`

## Requirements
- R1: After reset, tone_o and end_irq_o are both 0 and nothing plays until run_i rises.
- R2: When run_i rises with buzz_i at 0, the word at start_addr_i is fetched in the next cycle. The output stays low during that fetch cycle, and playback of that word begins in the cycle after.
- R3: For a note whose divider field (bits 7:0) holds a nonzero value D, the output has a period of D cycles. In each period it is high for the first D − floor(D/2) cycles and low for the rest, and every note starts at the beginning of a period.
- R4: A note whose divider field is 0 is a rest: the output stays low for the whole duration of that note.
- R5: A note lasts L × (16 − T) × 2^LEN_SHIFT cycles. L is the length field (bits 13:8) and T is tempo_i as it stands when the note is fetched.
- R6: A length field of 0 is treated as 1, and a tempo of 0 is treated as 1.
- R7: When a note without the end flag expires, the word at the next address is loaded in the same cycle and starts at once, with no gap cycle.
- R8: Bit 15 marks the last note. After that note expires, the cycle that follows has the output low and end_irq_o high for exactly one cycle, and the block returns to idle.
- R9: Driving run_i low during playback or buzzing forces the output low from the next cycle on, and end_irq_o is not raised.
- R10: When run_i rises with buzz_i at 1, the output becomes a square wave with a period of 8 cycles: high for 4 cycles, then low for 4. It starts high in the cycle after the edge, continues until run_i falls, and never raises end_irq_o.
- R11: If run_i stays high after a melody ends, the block stays idle with the output low. Playback starts again only on a new rising edge of run_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Run control; a rising edge starts, low stops |
| buzz_i | input | 1 | Selects fixed buzzer mode when run_i rises |
| tempo_i | input | 4 | Tempo code T; duration scale is 16 − T |
| start_addr_i | input | ADDR_W | ROM address of the first note |
| rom_addr_o | output | ADDR_W | Note ROM read address |
| rom_data_i | input | 16 | Note word: end[15], reserved[14], length[13:8], divider[7:0] |
| tone_o | output | 1 | Non-inverted tone output, low when idle |
| end_irq_o | output | 1 | One-cycle pulse when a melody completes |

## Verification
The hardest situation to reach is a note boundary. At that point the timer expires, the next word is fetched, and the divider phase restarts, all in the same cycle. A stretch of the waveform that is one cycle late or early looks almost the same as a correct one. The stimulus places short notes with different dividers back to back, including a rest and a divider of 1, and uses a small length scale. This gives many boundaries in a short run, and the bench model compares the pin against a per-cycle expected waveform across each of them. A separate run stops the melody in the middle of a note. This checks that the stop path overrides a pending interrupt.

// File: rtl/melody_pkg.sv
package melody_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PLAY = 2'd2,
        ST_BUZZ = 2'd3
    } mel_state_e;

    localparam int LEN_W   = 6;
    localparam int TEMPO_W = 4;
    localparam int DIV_W   = 8;

    // Note word layout; the end flag sits in the top bit.
    typedef struct packed {
        logic             last;
        logic             rsvd;
        logic [LEN_W-1:0] len;
        logic [DIV_W-1:0] div;
    } note_t;

endpackage

// File: rtl/mel_dur_timer.sv
module mel_dur_timer
    import melody_pkg::*;
#(
    parameter int LEN_SHIFT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic [TEMPO_W-1:0] tempo_i,
    output logic               expire_o
);

    localparam int CNT_W   = LEN_W + TEMPO_W + LEN_SHIFT;
    localparam int MAX_DUR = ((1 << LEN_W) - 1) * ((1 << TEMPO_W) - 1) * (1 << LEN_SHIFT);

    logic [CNT_W-1:0]   cnt_d, cnt_q;
    logic [CNT_W-1:0]   dur;
    logic [LEN_W-1:0]   len_eff;
    logic [TEMPO_W-1:0] tempo_eff;

    always_comb begin
        len_eff   = (len_i == '0) ? LEN_W'(1) : len_i;
        tempo_eff = (tempo_i == '0) ? TEMPO_W'(1) : tempo_i;
        dur       = (CNT_W'(len_eff) * (CNT_W'(1 << TEMPO_W) - CNT_W'(tempo_eff))) << LEN_SHIFT;
        cnt_d     = cnt_q;
        if (load_i) begin
            cnt_d = dur - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == '0);

    // R5: a loaded count never exceeds the longest legal note
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) <= 32'(MAX_DUR - 1));

endmodule

// File: rtl/mel_tone_gen.sv
module mel_tone_gen
    import melody_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tone_o
);

    logic [DIV_W-1:0] phase_d, phase_q;
    logic [DIV_W-1:0] hi_len;

    always_comb begin
        hi_len  = div_i - (div_i >> 1);
        phase_d = phase_q;
        if (restart_i) begin
            phase_d = '0;
        end else if (en_i) begin
            phase_d = (phase_q == div_i - DIV_W'(1)) ? '0 : phase_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    assign tone_o = en_i && (div_i != '0) && (phase_q < hi_len);

    // R3: phase stays inside the current period
    a_r3_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && div_i != '0) |-> (phase_q < div_i));

endmodule

// File: rtl/melody_seq.sv
module melody_seq
    import melody_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int LEN_SHIFT = 6,
    parameter int BUZZ_DIV  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               buzz_i,
    input  logic [TEMPO_W-1:0] tempo_i,
    input  logic [ADDR_W-1:0]  start_addr_i,
    output logic [ADDR_W-1:0]  rom_addr_o,
    input  logic [15:0]        rom_data_i,
    output logic               tone_o,
    output logic               end_irq_o
);

    typedef struct packed {
        mel_state_e        st;
        logic              run;
        logic [ADDR_W-1:0] ptr;
        note_t             note;
        logic              irq;
    } seq_t;

    seq_t             s_d, s_q;
    note_t            fetched;
    logic             start;
    logic             load;
    logic             restart;
    logic             expire;
    logic             gen_en;
    logic [DIV_W-1:0] div_sel;

    always_comb begin
        fetched = note_t'(rom_data_i);
        start   = run_i && !s_q.run;
        s_d     = s_q;
        s_d.run = run_i;
        s_d.irq = 1'b0;
        load    = 1'b0;
        restart = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (buzz_i) begin
                        s_d.st  = ST_BUZZ;
                        restart = 1'b1;
                    end else begin
                        s_d.st  = ST_LOAD;
                        s_d.ptr = start_addr_i;
                    end
                end
            end
            ST_LOAD: begin
                if (!run_i) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.note = fetched;
                    s_d.ptr  = s_q.ptr + ADDR_W'(1);
                    s_d.st   = ST_PLAY;
                    load     = 1'b1;
                    restart  = 1'b1;
                end
            end
            ST_PLAY: begin
                if (!run_i) begin
                    s_d.st = ST_IDLE;
                end else if (expire) begin
                    if (s_q.note.last) begin
                        s_d.st  = ST_IDLE;
                        s_d.irq = 1'b1;
                    end else begin
                        s_d.note = fetched;
                        s_d.ptr  = s_q.ptr + ADDR_W'(1);
                        load     = 1'b1;
                        restart  = 1'b1;
                    end
                end
            end
            ST_BUZZ: begin
                if (!run_i) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, run: 1'b0, ptr: '0, note: '0, irq: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign gen_en     = (s_q.st == ST_PLAY) || (s_q.st == ST_BUZZ);
    assign div_sel    = (s_q.st == ST_BUZZ) ? DIV_W'(BUZZ_DIV) : s_q.note.div;
    assign rom_addr_o = s_q.ptr;
    assign end_irq_o  = s_q.irq;

    mel_dur_timer #(.LEN_SHIFT(LEN_SHIFT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .len_i    (fetched.len),
        .tempo_i  (tempo_i),
        .expire_o (expire)
    );

    mel_tone_gen u_tone (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (gen_en),
        .restart_i (restart),
        .div_i     (div_sel),
        .tone_o    (tone_o)
    );

    // R8: the end interrupt is a single-cycle pulse
    a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq_o |=> !end_irq_o);

    // R8: the end interrupt only follows playback
    a_r8_irq_after_play: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq_o |-> ($past(s_q.st) == ST_PLAY));

    // R9: a low run control silences pin and interrupt in the next cycle
    a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!tone_o && !end_irq_o));

    // R10: buzzer mode never moves the ROM pointer and never interrupts
    a_r10_buzz_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_BUZZ && run_i) |=> ($stable(rom_addr_o) && !end_irq_o));

endmodule

// File: tb/melody_seq_tb_top.sv
module melody_seq_tb_top;

    localparam int AW    = 5;
    localparam int SHIFT = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          buzz = 1'b0;
    logic [3:0]    tempo = 4'd0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] rom_addr;
    logic [15:0]   rom_data;
    logic          tone;
    logic          irq;

    logic [15:0] rom [32];
    int n_checks = 0;
    int n_fail   = 0;

    logic [1:0] expq [$];
    string      reqq [$];

    always #4 clk = ~clk;

    assign rom_data = rom[rom_addr];

    melody_seq #(.ADDR_W(AW), .LEN_SHIFT(SHIFT), .BUZZ_DIV(8)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .buzz_i       (buzz),
        .tempo_i      (tempo),
        .start_addr_i (start_addr),
        .rom_addr_o   (rom_addr),
        .rom_data_i   (rom_data),
        .tone_o       (tone),
        .end_irq_o    (irq)
    );

    function automatic logic [15:0] mkw(input bit last, input int len, input int dv);
        return {last, 1'b0, 6'(len), 8'(dv)};
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic build(input int addr, input int tmp, input int trail);
        int a = addr;
        int first = 1;
        int te = (tmp == 0) ? 1 : tmp;
        expq.push_back(2'b00); reqq.push_back("R2 fetch");
        forever begin
            logic [15:0] w = rom[a];
            int ln = int'(w[13:8]);
            int dv = int'(w[7:0]);
            int le = (ln == 0) ? 1 : ln;
            int dur = le * (16 - te) * (1 << SHIFT);
            string tag = (dv == 0) ? "R4 R5" : "R3 R5";
            if (!first) tag = {tag, " R7"};
            if (ln == 0 || tmp == 0) tag = {tag, " R6"};
            for (int i = 0; i < dur; i++) begin
                logic t = (dv != 0) && ((i % dv) < (dv - dv / 2));
                expq.push_back({1'b0, t}); reqq.push_back(tag);
            end
            first = 0;
            if (w[15]) break;
            a++;
        end
        expq.push_back(2'b10); reqq.push_back("R8 end");
        for (int i = 0; i < trail; i++) begin
            expq.push_back(2'b00); reqq.push_back("R11 held");
        end
    endtask

    task automatic play(input int addr, input int tmp, input int trail, input int stop_after);
        int n = 0;
        build(addr, tmp, trail);
        @(negedge clk);
        tempo = 4'(tmp); start_addr = AW'(addr); buzz = 1'b0; run = 1'b1;
        while (expq.size() > 0) begin
            logic [1:0] e;
            string r;
            @(posedge clk); @(negedge clk);
            e = expq.pop_front(); r = reqq.pop_front();
            chk({r, " tone"}, tone, e[0]);
            chk({r, " irq"}, irq, e[1]);
            n++;
            if (stop_after != 0 && n == stop_after) begin
                expq.delete(); reqq.delete();
            end
        end
        run = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R9 after stop tone", tone, 1'b0);
            chk("R9 after stop irq", irq, 1'b0);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) rom[i] = 16'h0;
        rom[0]  = mkw(0, 3, 11);
        rom[1]  = mkw(0, 2, 0);
        rom[2]  = mkw(0, 1, 5);
        rom[3]  = mkw(1, 2, 1);
        rom[8]  = mkw(0, 0, 6);
        rom[9]  = mkw(1, 2, 62);
        rom[12] = mkw(1, 1, 3);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset tone", tone, 1'b0);
        chk("R1 reset irq", irq, 1'b0);
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            chk("R1 idle tone", tone, 1'b0);
        end

        play(0, 14, 2, 0);
        play(8, 0, 2, 0);
        play(12, 15, 10, 0);
        play(0, 14, 0, 10);

        @(negedge clk);
        buzz = 1'b1; run = 1'b1;
        for (int i = 0; i < 24; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R10 buzz tone", tone, (i % 8) < 4);
            chk("R10 buzz irq", irq, 1'b0);
        end
        run = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R9 R10 buzz stop tone", tone, 1'b0);
            chk("R9 R10 buzz stop irq", irq, 1'b0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule